// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block performs a single read or write bus cycle toward a NAND Flash device. Its shape comes from four 8-bit timing fields packed into one 32-bit configuration word. When the host raises a request, the block latches the address, the direction, the write data and the timing fields. It then runs four phases in order:

- **Setup.** The address is presented with both strobes high.
- **Strobe.** The active-low write or read strobe is asserted. It can be stretched by an active-low wait input from the device.
- **Hold.** The address, and on writes the data, stay in place after the strobe is released.
- **Done.** A one-cycle completion pulse is raised.

On writes, a separate timer keeps the data bus in high impedance for a programmed number of cycles from the start of the access.

The fields use different encodings. Setup and strobe count their field value plus one cycle. Hold counts its field value on writes and its field value plus two on reads. Reserved encodings are clamped to the nearest legal value and recorded in a sticky error flag. The wait input is synchronized internally, so it may be fully asynchronous. Read data is latched from the data bus on the last strobe cycle.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the configuration word reads 0xFCFCFCFC. Both strobes are high, the data bus is not driven, done is low, busy is low and the error flag is clear. The field layout is: data-bus float time in bits 31:24, hold in bits 23:16, strobe width in bits 15:8, setup in bits 7:0. With the reset word, a write access has 253 setup cycles, 253 strobe cycles, 252 hold cycles and 252 float cycles.
- R2: The setup phase lasts (setup field + 1) cycles. During it busy is high, the latched address is on the address output and both strobes are high.
- R3: When wait is high, the strobe lasts exactly (strobe field + 1) cycles. A write lowers only the write strobe and a read lowers only the read strobe; the two are never low together.
- R4: The block checks the synchronized wait input in the last programmed strobe cycle. If wait is low there, the strobe is extended until the synchronized value is high. If wait is raised during strobe cycle j, the strobe lasts max(strobe field + 1, j + 2) cycles.
- R5: After the strobe is released, the hold phase lasts (hold field) cycles on a write and (hold field + 2) cycles on a read. The address stays unchanged for the whole access.
- R6: On a write, the data output enable stays low for the first (float field) cycles of the access. It then stays high, carrying the latched write data, until the access ends. A field of 0 enables the bus in the first cycle. A read never enables the data bus.
- R7: On a read, the read-data output takes the data-bus value present at the clock edge that ends the last strobe cycle.
- R8: Done is high for exactly one cycle, directly after the last hold cycle. In that same cycle busy is low.
- R9: Reserved encodings are clamped when an access starts: 0xFF in any field becomes 0xFE, and 0x00 in the strobe or hold field becomes 0x01. Writing a word that contains any reserved encoding sets the error flag. The flag stays set until reset. The configuration readback returns the raw value that was written.
- R10: The request inputs, direction, address, write data and timing fields are captured when an idle cycle accepts a request. Configuration writes, changed inputs and further requests during a busy access do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_wdata | input | 32 | Configuration word write value |
| cfg_rdata | output | 32 | Configuration word readback |
| cfg_error | output | 1 | Sticky flag for a reserved encoding written |
| req | input | 1 | Access request, accepted while idle |
| wr | input | 1 | Direction: 1 write, 0 read |
| addr_in | input | ADDR_W | Access address |
| wdata_in | input | DATA_W | Write data |
| rdata | output | DATA_W | Captured read data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| wait_n | input | 1 | Asynchronous active-low wait from the device |
| nand_addr | output | ADDR_W | Address to the device |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_oe_n | output | 1 | Active-low read strobe |
| dq_out | output | DATA_W | Data toward the device |
| dq_oe | output | 1 | Data output enable |
| dq_in | input | DATA_W | Data from the device |

## Verification
The bound checker watches several properties on every clock cycle:
- The two strobes never fall together.
- A strobe only falls after at least one setup cycle.
- The address is stable throughout an access.
- The data bus is never driven while the read strobe is low, or while the block is idle.
- Done is a lone pulse that falls outside busy.
- The error flag is sticky.

Other behaviours only show up in the bench's scenarios, which measure the phase lengths at the ports:
- The exact count of each phase for each encoding, including the read-versus-write hold offset.
- The wait stretch.
- The float interval.
- Which data-bus value becomes the read data.
- Clamping of reserved values.
- The immunity of a running access to configuration writes and stray requests.

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq #(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] CFG_RESET   = 32'hFCFC_FCFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              cfg_error,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              done,
  input  logic              wait_n,
  output logic [ADDR_W-1:0] nand_addr,
  output logic              nand_we_n,
  output logic              nand_oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int         CNT_W = 9;
  localparam logic [7:0] F_TOP = 8'hFE;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} state_t;

  state_t              state;
  logic [31:0]         cfg_q;
  logic                err_q;
  logic [CNT_W-1:0]    cnt;
  logic [7:0]          hz_cnt;
  logic [7:0]          wait_q, hold_q;
  logic                wr_q, done_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q, rdata_q;
  logic [SYNC_STAGES-1:0] wsync;

  wire [7:0] f_set  = cfg_q[7:0];
  wire [7:0] f_wait = cfg_q[15:8];
  wire [7:0] f_hold = cfg_q[23:16];
  wire [7:0] f_hiz  = cfg_q[31:24];

  wire [7:0] set_c  = (f_set  == 8'hFF) ? F_TOP : f_set;
  wire [7:0] hiz_c  = (f_hiz  == 8'hFF) ? F_TOP : f_hiz;
  wire [7:0] wait_c = (f_wait == 8'h00) ? 8'h01 : (f_wait == 8'hFF) ? F_TOP : f_wait;
  wire [7:0] hold_c = (f_hold == 8'h00) ? 8'h01 : (f_hold == 8'hFF) ? F_TOP : f_hold;

  wire bad_word = (cfg_wdata[31:24] == 8'hFF) ||
                  (cfg_wdata[23:16] == 8'hFF) || (cfg_wdata[23:16] == 8'h00) ||
                  (cfg_wdata[15:8]  == 8'hFF) || (cfg_wdata[15:8]  == 8'h00) ||
                  (cfg_wdata[7:0]   == 8'hFF);

  wire wait_hi  = wsync[SYNC_STAGES-1];
  wire cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      err_q <= 1'b0;
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
      if (bad_word) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wsync <= '1;
    else        wsync <= {wsync[SYNC_STAGES-2:0], wait_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      hz_cnt  <= '0;
      wait_q  <= '0;
      hold_q  <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state != ST_IDLE && hz_cnt != '0) hz_cnt <= hz_cnt - 8'd1;
      case (state)
        ST_IDLE: begin
          if (req) begin
            state   <= ST_SETUP;
            cnt     <= CNT_W'(set_c);
            hz_cnt  <= hiz_c;
            wait_q  <= wait_c;
            hold_q  <= hold_c;
            wr_q    <= wr;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state <= ST_STROBE;
            cnt   <= CNT_W'(wait_q);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (!cnt_zero) begin
            cnt <= cnt - 1'b1;
          end else if (wait_hi) begin
            state <= ST_HOLD;
            cnt   <= wr_q ? CNT_W'(hold_q) - 1'b1 : CNT_W'(hold_q) + 2'd1;
            if (!wr_q) rdata_q <= dq_in;
          end
        end
        default: begin
          if (cnt_zero) begin
            state  <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign cfg_rdata = cfg_q;
  assign cfg_error = err_q;
  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign nand_addr = addr_q;
  assign dq_out    = wdata_q;
  assign nand_we_n = !(state == ST_STROBE && wr_q);
  assign nand_oe_n = !(state == ST_STROBE && !wr_q);
  assign dq_oe     = busy && wr_q && (hz_cnt == '0);

endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              nand_we_n,
  input logic              nand_oe_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] nand_addr,
  input logic              cfg_error
);

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_oe_n));

  // R2
  strobe_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nand_we_n) || $fell(nand_oe_n)) |-> ($past(busy) && $past(nand_we_n) && $past(nand_oe_n)));

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(nand_addr));

  // R6
  no_read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (busy && nand_oe_n));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && nand_we_n && nand_oe_n));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> cfg_error);

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n), .dq_oe(dq_oe),
  .nand_addr(nand_addr), .cfg_error(cfg_error)
);

// File: tb/sim_nand_cycle_seq.sv
`timescale 1ns/1ps
module sim_nand_cycle_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_error;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] addr_in = '0;
  logic [7:0]  wdata_in = '0;
  logic [7:0]  rdata;
  logic        busy, done;
  logic        wait_n = 1'b1;
  logic [15:0] nand_addr;
  logic        nand_we_n, nand_oe_n;
  logic [7:0]  dq_out;
  logic        dq_oe;
  logic [7:0]  dq_in = '0;

  always #4 clk = ~clk;

  nand_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_error(cfg_error), .req(req), .wr(wr),
    .addr_in(addr_in), .wdata_in(wdata_in), .rdata(rdata), .busy(busy),
    .done(done), .wait_n(wait_n), .nand_addr(nand_addr),
    .nand_we_n(nand_we_n), .nand_oe_n(nand_oe_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  int  m_setup, m_strobe, m_hold, m_hiz;
  int  m_done1, m_done2, m_bad_addr, m_bad_other, m_bad_data, m_rd_drive;
  logic [7:0] m_last_rd;
  logic [7:0] dq_val = 8'h3C;

  // {release cycle[7:0], wr, cfg[31:0]}
  localparam int NV = 8;
  localparam logic [40:0] VEC [NV] = '{
    {8'd0, 1'b1, 32'h02_03_02_01},
    {8'd0, 1'b0, 32'h02_03_02_01},
    {8'd0, 1'b1, 32'h00_01_01_00},
    {8'd0, 1'b0, 32'h00_01_01_00},
    {8'd0, 1'b1, 32'h05_02_04_03},
    {8'd5, 1'b0, 32'h00_04_01_02},
    {8'd2, 1'b1, 32'h01_02_03_00},
    {8'd1, 1'b0, 32'h00_01_04_01}
  };

  function automatic int cl_ff(input logic [7:0] f);
    return (f == 8'hFF) ? 254 : int'(f);
  endfunction
  function automatic int cl_both(input logic [7:0] f);
    return (f == 8'h00) ? 1 : cl_ff(f);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic put_cfg(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic w, input logic [15:0] a, input logic [7:0] d,
                     input int rel, input bit mid, input logic [31:0] mid_cfg);
    bit seen, oe_seen, strobe_now, other;
    int iter, guard;
    wait_n = (rel == 0);
    repeat (3) @(negedge clk);
    req = 1'b1; wr = w; addr_in = a; wdata_in = d;
    m_setup = 0; m_strobe = 0; m_hold = 0; m_hiz = 0;
    m_bad_addr = 0; m_bad_other = 0; m_bad_data = 0; m_rd_drive = 0;
    seen = 0; oe_seen = 0; iter = 0; guard = 0;
    @(negedge clk);
    req = 1'b0; addr_in = ~a; wdata_in = ~d; wr = ~w;
    while (busy && guard < 3000) begin
      guard++; iter++;
      if (mid && iter == 2) begin
        cfg_we = 1'b1; cfg_wdata = mid_cfg; req = 1'b1;
      end else if (mid && iter == 3) begin
        cfg_we = 1'b0; req = 1'b0;
      end
      strobe_now = w ? !nand_we_n : !nand_oe_n;
      other      = w ? !nand_oe_n : !nand_we_n;
      if (other) m_bad_other = 1;
      if (nand_addr != a) m_bad_addr = 1;
      if (!seen && !strobe_now) m_setup++;
      else if (strobe_now) begin
        seen = 1; m_strobe++;
        if (rel != 0 && m_strobe == rel) wait_n = 1'b1;
      end else m_hold++;
      if (w) begin
        if (!dq_oe && !oe_seen) m_hiz++;
        if (dq_oe) begin
          oe_seen = 1;
          if (dq_out != d) m_bad_data = 1;
        end else if (oe_seen) m_bad_data = 1;
      end else if (dq_oe) m_rd_drive = 1;
      dq_val = dq_val * 8'd5 + 8'd3;
      dq_in = dq_val;
      if (!w && strobe_now) m_last_rd = dq_val;
      @(negedge clk);
    end
    m_done1 = int'(done);
    @(negedge clk);
    m_done2 = int'(done);
    wait_n = 1'b1;
  endtask

  task automatic check_access(input string tag, input logic w, input int es,
                              input int ew, input int eh, input int ez);
    chk({tag, " R2 setup"}, m_setup, es);
    chk({tag, " R3/R4 strobe"}, m_strobe, ew);
    chk({tag, " R5 hold"}, m_hold, w ? eh : eh + 2);
    chk({tag, " R5 addr"}, m_bad_addr, 0);
    chk({tag, " R3 other strobe"}, m_bad_other, 0);
    if (w) begin
      chk({tag, " R6 float"}, m_hiz, ez);
      chk({tag, " R6 data"}, m_bad_data, 0);
    end else begin
      chk({tag, " R6 read drive"}, m_rd_drive, 0);
      chk({tag, " R7 rdata"}, int'(rdata), int'(m_last_rd));
    end
    chk({tag, " R8 done"}, m_done1, 1);
    chk({tag, " R8 pulse"}, m_done2, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cfg reset", int'(cfg_rdata == 32'hFCFC_FCFC), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cfg after reset", int'(cfg_rdata == 32'hFCFC_FCFC), 1);
    chk("R1 busy", int'(busy), 0);
    chk("R1 strobes", int'({nand_we_n, nand_oe_n}), 3);
    chk("R1 dq_oe", int'(dq_oe), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 error", int'(cfg_error), 0);

    // R1 reset timing word in use
    run(1'b1, 16'hBEEF, 8'h5A, 0, 0, '0);
    check_access("R1", 1'b1, 253, 253, 252, 252);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] c;
      logic        w;
      int          rel, ew;
      c = VEC[i][31:0]; w = VEC[i][32]; rel = int'(VEC[i][40:33]);
      put_cfg(c);
      run(w, 16'h1000 + 16'(i), 8'hA0 + 8'(i), rel, 0, '0);
      ew = cl_both(c[15:8]) + 1;
      if (rel != 0 && rel + 2 > ew) ew = rel + 2;
      check_access($sformatf("vec%0d", i), w, cl_ff(c[7:0]) + 1, ew,
                   cl_both(c[23:16]), cl_ff(c[31:24]));
    end
    chk("R9 no error on legal", int'(cfg_error), 0);

    // R9 clamp: setup FF, hold 00, wait 00
    put_cfg(32'h00_00_00_FF);
    chk("R9 error set", int'(cfg_error), 1);
    chk("R9 raw readback", int'(cfg_rdata == 32'h00_00_00_FF), 1);
    run(1'b1, 16'h7777, 8'h11, 0, 0, '0);
    check_access("R9 clamp", 1'b1, 255, 2, 1, 0);
    put_cfg(32'h00_02_02_02);
    chk("R9 sticky", int'(cfg_error), 1);

    // R10 config write and stray request during access
    put_cfg(32'h00_03_02_02);
    run(1'b1, 16'h4242, 8'hC3, 0, 1, 32'h00_09_09_09);
    check_access("R10 mid", 1'b1, 3, 3, 3, 0);
    chk("R10 new cfg stored", int'(cfg_rdata == 32'h00_09_09_09), 1);
    run(1'b0, 16'h0101, 8'h00, 0, 0, '0);
    check_access("R10 next", 1'b0, 10, 10, 9, 0);

    summary();
  end

endmodule